// File: doc/BRIEF.md
# Path ORAM Stash Eviction Scanner

This block decides, for every block that could be written back during a Path ORAM eviction, which bucket on the current eviction path should receive it. A scan begins with a start pulse that also carries the leaf of the eviction path. Candidate entries then arrive one per cycle, with gaps allowed. Entries already resident in the stash come first, and path blocks follow as memory returns them. Each entry carries a real/dummy flag, the leaf it is mapped to, and its stash index.

For each real entry the block finds the deepest bucket that lies on both the eviction path and the entry's own path and still has a free slot. It uses a carry-chain bit trick for this, so no sort is needed. The entry's stash index is then recorded in a pointer array that has one slot per block position on the path. A per-level occupancy count decides which slot within a bucket is used next.

Once the entry flagged as final has passed through the pipeline, a done flag rises. A later write-back engine then reads the pointer array through a slot-addressed read port.

Top module: `stash_evict_scan`

## Requirements
- R1: After reset, scanDone is low and every pointer slot reads as empty (rdPtrValid low).
- R2: A startPulse captures evictLeaf, empties every pointer slot, clears all LEVELS+1 occupancy counts and drops scanDone in the following cycle. Entries strobed in the same cycle as startPulse are discarded.
- R3: Leaf bit i selects the left (0) or right (1) child below the level-i bucket, with level 0 the root and level LEVELS the leaves. A real entry may be placed at level v only if bits 0 to v-1 of its leaf equal those of the eviction leaf.
- R4: Among the legal levels whose occupancy is below SLOTS, a real entry is placed at the deepest one.
- R5: An entry placed at level v is written to slot v*SLOTS + occupancy(v), so entries at one level fill its slots in arrival order. That level's occupancy is then incremented.
- R6: An entry strobed with inReal low is never placed and consumes no occupancy.
- R7: A real entry whose legal levels are all full is left unplaced, and no slot changes.
- R8: One entry per cycle is accepted while a scan is open, with idle cycles permitted between entries. Strobes before the first start, or after the final entry has been accepted, leave the pointer array unchanged.
- R9: scanDone rises on the second rising edge after the edge that accepts the entry strobed with inLast. It stays high until the next startPulse.
- R10: rdPtrValid and rdPtr show combinationally whether slot rdSlot is filled and which stash index it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Opens a new scan and clears all state |
| evictLeaf | input | LEVELS | Eviction path leaf, sampled with startPulse |
| inStrobe | input | 1 | Candidate entry present this cycle |
| inReal | input | 1 | Entry holds a real block (low means dummy) |
| inLeaf | input | LEVELS | Leaf the entry is mapped to |
| inIndex | input | $clog2(STASH_DEPTH) | Stash index of the entry |
| inLast | input | 1 | Entry is the final one of this scan |
| rdSlot | input | $clog2((LEVELS+1)*SLOTS) | Pointer slot to read |
| rdPtrValid | output | 1 | Addressed slot holds a pointer |
| rdPtr | output | $clog2(STASH_DEPTH) | Stash index held by the addressed slot |
| scanDone | output | 1 | Final entry has been processed |

## Verification
The assertions assume that every scan is closed by exactly one inLast strobe, and that startPulse never arrives while entries are still inside the pipeline. They also assume that no more entries are offered than the block can absorb. Under those conditions the block makes at most one one-hot placement per cycle, never fills more slots than the path holds, and stays quiet while done is high.

The stimulus opens every scan with a lone start pulse and raises inLast only on the final entry. It then waits for done before reading slots or starting again. Strobes sent after done test the requirement that such strobes are ignored, which falls outside what the assertions assume.

// File: rtl/stash_evict_pkg.sv
package stash_evict_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DRAIN,
    ST_DONE
  } scan_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic acceptEn;
  } scan_ctrl_t;

endpackage

// File: rtl/stash_evict_pick.sv
// Chooses the deepest free level out of a legal-level mask.
module stash_evict_pick #(
  parameter int NLVL  = 4,
  parameter int LVL_W = 2
) (
  input  logic [NLVL-1:0]  legalMask,
  input  logic [NLVL-1:0]  fullVec,
  output logic [NLVL-1:0]  levelHot,
  output logic [LVL_W-1:0] levelIdx,
  output logic             levelAny
);

  logic [NLVL-1:0] avail;
  logic [NLVL-1:0] availRev;
  logic [NLVL-1:0] isoRev;

  assign avail = legalMask & ~fullVec;

  // mirror so the deepest level becomes the lowest bit
  for (genvar g = 0; g < NLVL; g++) begin : g_rev
    assign availRev[g]            = avail[NLVL-1-g];
    assign levelHot[NLVL-1-g]     = isoRev[g];
  end

  assign isoRev   = availRev & (~availRev + 1'b1);
  assign levelAny = |avail;

  always_comb begin
    levelIdx = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (levelHot[i]) levelIdx = levelIdx | LVL_W'(i);
    end
  end

endmodule

// File: rtl/stash_evict_ctrl.sv
module stash_evict_ctrl
  import stash_evict_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       inStrobe,
  input  logic       inLast,
  input  logic       lastRetired,
  output scan_ctrl_t ctrl,
  output logic       scanDone
);

  scan_state_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (startPulse) begin
      state <= ST_SCAN;
    end else begin
      case (state)
        ST_SCAN:  if (inStrobe && inLast) state <= ST_DRAIN;
        ST_DRAIN: if (lastRetired)        state <= ST_DONE;
        default:  state <= state;
      endcase
    end
  end

  always_comb begin
    ctrl.clearAll = startPulse;
    ctrl.acceptEn = (state == ST_SCAN) && !startPulse;
  end

  assign scanDone = (state == ST_DONE);

endmodule

// File: rtl/stash_evict_dp.sv
// Three-step placement pipeline, occupancy counters and pointer slots.
module stash_evict_dp
  import stash_evict_pkg::*;
#(
  parameter int LEVELS      = 3,
  parameter int SLOTS       = 4,
  parameter int STASH_DEPTH = 32,
  localparam int NLVL   = LEVELS + 1,
  localparam int NSLOT  = NLVL * SLOTS,
  localparam int IDX_W  = $clog2(STASH_DEPTH),
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int LVL_W  = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int OCC_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scan_ctrl_t        ctrl,
  input  logic [LEVELS-1:0] evictLeaf,
  input  logic              inStrobe,
  input  logic              inReal,
  input  logic [LEVELS-1:0] inLeaf,
  input  logic [IDX_W-1:0]  inIndex,
  input  logic              inLast,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic              rdPtrValid,
  output logic [IDX_W-1:0]  rdPtr,
  output logic              lastRetired,
  output logic [NLVL-1:0]   commitHot
);

  logic [LEVELS-1:0] leafQ;

  // stage 1: divergence, lowest set bit
  logic [NLVL-1:0]  divVec;
  logic [NLVL-1:0]  divLow;
  logic             s1Valid, s1Real, s1Last;
  logic [IDX_W-1:0] s1Idx;
  logic [NLVL-1:0]  s1Low;

  // stage 2: legal-level mask
  logic             s2Valid, s2Real, s2Last;
  logic [IDX_W-1:0] s2Idx;
  logic [NLVL-1:0]  s2Legal;

  // stage 3: occupancy read, pick, write, occupancy update
  logic [OCC_W-1:0] occ [NLVL];
  logic [NLVL-1:0]  fullVec;
  logic [NLVL-1:0]  pickHot;
  logic [LVL_W-1:0] pickIdx;
  logic             pickAny;
  logic             commitFire;
  logic [SLOT_W-1:0] slotSel;

  logic             slotValid [NSLOT];
  logic [IDX_W-1:0] slotPtr   [NSLOT];

  always_ff @(posedge clk) begin
    if (!rstN) leafQ <= '0;
    else if (ctrl.clearAll) leafQ <= evictLeaf;
  end

  assign divVec = {inLeaf ^ leafQ, 1'b0};
  assign divLow = divVec & (~divVec + 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearAll) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= inStrobe && ctrl.acceptEn;
      s2Valid <= s1Valid;
    end
  end

  always_ff @(posedge clk) begin
    s1Real  <= inReal;
    s1Last  <= inLast;
    s1Idx   <= inIndex;
    s1Low   <= divLow;
    s2Real  <= s1Real;
    s2Last  <= s1Last;
    s2Idx   <= s1Idx;
    s2Legal <= s1Low - 1'b1;
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_full
    assign fullVec[g] = (occ[g] == OCC_W'(SLOTS));
  end

  stash_evict_pick #(
    .NLVL  (NLVL),
    .LVL_W (LVL_W)
  ) i_pick (
    .legalMask (s2Legal),
    .fullVec   (fullVec),
    .levelHot  (pickHot),
    .levelIdx  (pickIdx),
    .levelAny  (pickAny)
  );

  assign commitFire = s2Valid && s2Real && pickAny;
  assign slotSel    = SLOT_W'(pickIdx) * SLOT_W'(SLOTS) + SLOT_W'(occ[pickIdx]);
  assign commitHot  = (s2Valid && s2Real) ? pickHot : '0;
  assign lastRetired = s2Valid && s2Last;

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearAll) begin
      for (int i = 0; i < NLVL; i++) occ[i] <= '0;
    end else if (commitFire) begin
      for (int i = 0; i < NLVL; i++) begin
        if (pickIdx == LVL_W'(i)) occ[i] <= occ[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearAll) begin
      for (int s = 0; s < NSLOT; s++) begin
        slotValid[s] <= 1'b0;
        slotPtr[s]   <= '0;
      end
    end else if (commitFire) begin
      slotValid[slotSel] <= 1'b1;
      slotPtr[slotSel]   <= s2Idx;
    end
  end

  assign rdPtrValid = slotValid[rdSlot];
  assign rdPtr      = slotPtr[rdSlot];

endmodule

// File: rtl/stash_evict_scan.sv
module stash_evict_scan
  import stash_evict_pkg::*;
#(
  parameter int LEVELS      = 3,
  parameter int SLOTS       = 4,
  parameter int STASH_DEPTH = 32,
  localparam int NLVL   = LEVELS + 1,
  localparam int IDX_W  = $clog2(STASH_DEPTH),
  localparam int SLOT_W = $clog2(NLVL * SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [LEVELS-1:0] evictLeaf,
  input  logic              inStrobe,
  input  logic              inReal,
  input  logic [LEVELS-1:0] inLeaf,
  input  logic [IDX_W-1:0]  inIndex,
  input  logic              inLast,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic              rdPtrValid,
  output logic [IDX_W-1:0]  rdPtr,
  output logic              scanDone
);

  scan_ctrl_t      ctrl;
  logic            lastRetired;
  logic [NLVL-1:0] commitHot;

  stash_evict_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .inStrobe    (inStrobe),
    .inLast      (inLast),
    .lastRetired (lastRetired),
    .ctrl        (ctrl),
    .scanDone    (scanDone)
  );

  stash_evict_dp #(
    .LEVELS      (LEVELS),
    .SLOTS       (SLOTS),
    .STASH_DEPTH (STASH_DEPTH)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .evictLeaf   (evictLeaf),
    .inStrobe    (inStrobe),
    .inReal      (inReal),
    .inLeaf      (inLeaf),
    .inIndex     (inIndex),
    .inLast      (inLast),
    .rdSlot      (rdSlot),
    .rdPtrValid  (rdPtrValid),
    .rdPtr       (rdPtr),
    .lastRetired (lastRetired),
    .commitHot   (commitHot)
  );

endmodule

// File: rtl/stash_evict_chk.sv
module stash_evict_chk #(
  parameter int NLVL  = 4,
  parameter int NSLOT = 16,
  localparam int CNT_W = $clog2(NSLOT + 2) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            startPulse,
  input logic            scanDone,
  input logic            rdPtrValid,
  input logic [NLVL-1:0] commitHot
);

  logic [CNT_W-1:0] placeCnt;

  always_ff @(posedge clk) begin
    if (!rstN || startPulse) placeCnt <= '0;
    else if (|commitHot)     placeCnt <= placeCnt + 1'b1;
  end

  AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(commitHot)); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (!scanDone && !rdPtrValid)); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && !startPulse) |=> scanDone); // R9

  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> (commitHot == '0)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    placeCnt <= CNT_W'(NSLOT)); // R7

endmodule

bind stash_evict_scan stash_evict_chk #(
  .NLVL  (LEVELS + 1),
  .NSLOT ((LEVELS + 1) * SLOTS)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .scanDone   (scanDone),
  .rdPtrValid (rdPtrValid),
  .commitHot  (commitHot)
);

// File: tb/test_stash_evict_scan.sv
`timescale 1ns/1ps
module test_stash_evict_scan;

  localparam int LEVELS = 3;
  localparam int SLOTS  = 4;
  localparam int DEPTH  = 32;
  localparam int NSLOT  = (LEVELS + 1) * SLOTS;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SLOT_W = $clog2(NSLOT);

  // {evict leaf[15:13], entry count[12:8], seed[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {3'd0, 5'd6,  8'd17},
    {3'd5, 5'd12, 8'd203},
    {3'd7, 5'd20, 8'd4},
    {3'd2, 5'd31, 8'd99},
    {3'd3, 5'd1,  8'd250},
    {3'd6, 5'd25, 8'd61},
    {3'd1, 5'd16, 8'd142},
    {3'd4, 5'd28, 8'd7}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [LEVELS-1:0] evictLeaf = '0;
  logic inStrobe = 1'b0;
  logic inReal = 1'b0;
  logic [LEVELS-1:0] inLeaf = '0;
  logic [IDX_W-1:0] inIndex = '0;
  logic inLast = 1'b0;
  logic [SLOT_W-1:0] rdSlot = '0;
  logic rdPtrValid;
  logic [IDX_W-1:0] rdPtr;
  logic scanDone;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  bit expValid [NSLOT];
  int expPtr   [NSLOT];
  int mOcc     [LEVELS+1];

  always #2.5 clk = ~clk;

  stash_evict_scan #(
    .LEVELS(LEVELS), .SLOTS(SLOTS), .STASH_DEPTH(DEPTH)
  ) i_stash_evict_scan (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .evictLeaf(evictLeaf),
    .inStrobe(inStrobe), .inReal(inReal), .inLeaf(inLeaf), .inIndex(inIndex),
    .inLast(inLast), .rdSlot(rdSlot), .rdPtrValid(rdPtrValid), .rdPtr(rdPtr),
    .scanDone(scanDone)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // read every slot and compare; value encoded as valid*100+ptr
  task automatic checkSlots(input string req);
    for (int s = 0; s < NSLOT; s++) begin
      rdSlot = SLOT_W'(s);
      #0.5;
      begin
        int act;
        int exp;
        act = rdPtrValid ? 100 + int'(rdPtr) : 0;
        exp = expValid[s] ? 100 + expPtr[s] : 0;
        chk(act == exp, $sformatf("%s R10 slot %0d", req, s), act, exp);
      end
    end
  endtask

  // behavioural placement: walk from the leaf level up to the root
  task automatic modelPlace(input int ev, input int leaf, input int idx);
    for (int lvl = LEVELS; lvl >= 0; lvl--) begin
      if ((((ev ^ leaf) & ((1 << lvl) - 1)) == 0) && mOcc[lvl] < SLOTS) begin
        expValid[lvl*SLOTS + mOcc[lvl]] = 1'b1;
        expPtr[lvl*SLOTS + mOcc[lvl]]   = idx;
        mOcc[lvl]++;
        break;
      end
    end
  endtask

  // mode 0: pseudo-random entries with gaps; 1: all real, fixed leaf; 2: all dummy
  task automatic runScan(input int ev, input int n, input int seed, input int mode,
                         input int fixedLeaf, input string req);
    int s;
    s = seed;
    for (int i = 0; i < NSLOT; i++) begin expValid[i] = 1'b0; expPtr[i] = 0; end
    for (int i = 0; i <= LEVELS; i++) mOcc[i] = 0;
    @(negedge clk);
    startPulse = 1'b1;
    evictLeaf  = LEVELS'(ev);
    @(negedge clk);
    startPulse = 1'b0;
    for (int b = 0; b < n; b++) begin
      bit real_b;
      int leaf;
      s = (s * 37 + 11) % 256;
      real_b = (mode == 2) ? 1'b0 : (mode == 1) ? 1'b1 : ((s >> 5) != 0);
      leaf = (mode == 1) ? fixedLeaf : (s & 7);
      if (mode == 0 && (s & 8) != 0) begin
        inStrobe = 1'b0;
        @(negedge clk);
      end
      if (real_b) modelPlace(ev, leaf, b);
      inStrobe = 1'b1;
      inReal   = real_b;
      inLeaf   = LEVELS'(leaf);
      inIndex  = IDX_W'(b);
      inLast   = (b == n - 1);
      @(negedge clk);
    end
    inStrobe = 1'b0;
    inLast   = 1'b0;
    chk(scanDone == 1'b0, "R9 done after accept edge", scanDone, 0);
    @(negedge clk);
    chk(scanDone == 1'b0, "R9 done one edge later", scanDone, 0);
    @(negedge clk);
    chk(scanDone == 1'b1, "R9 done two edges later", scanDone, 1);
    checkSlots(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(scanDone == 1'b0, "R1 done after reset", scanDone, 0);
    for (int i = 0; i < NSLOT; i++) begin expValid[i] = 1'b0; expPtr[i] = 0; end
    checkSlots("R1");

    // R8 strobes before any start are ignored
    inStrobe = 1'b1; inReal = 1'b1; inLeaf = '0; inIndex = 5; inLast = 1'b1;
    repeat (4) @(negedge clk);
    inStrobe = 1'b0; inLast = 1'b0;
    repeat (3) @(negedge clk);
    chk(scanDone == 1'b0, "R8 no done without start", scanDone, 0);
    checkSlots("R8 pre-start");

    // table of mixed scans: R3 R4 R5 R6 R8 with gaps
    for (int v = 0; v < 8; v++) begin
      runScan(int'(VEC[v][15:13]), int'(VEC[v][12:8]), int'(VEC[v][7:0]), 0, 0,
              "R3 R4 R5 R8");
    end

    // all entries on the eviction path: deepest first, overflow stays in stash
    runScan(5, 20, 0, 1, 5, "R4 R5 R7");
    // diverge right below the root: only root slots usable
    runScan(2, 9, 0, 1, 3, "R3 R7");
    // diverge below level 2: levels 0..2 usable
    runScan(6, 14, 0, 1, 2, "R3 R4");

    // R8 strobes after the final entry are ignored; R9 done holds
    inStrobe = 1'b1; inReal = 1'b1; inLeaf = 3'd2; inIndex = 9;
    repeat (5) @(negedge clk);
    inStrobe = 1'b0;
    repeat (3) @(negedge clk);
    chk(scanDone == 1'b1, "R9 done holds", scanDone, 1);
    checkSlots("R8 post-done");

    // R6 all dummies
    runScan(3, 10, 0, 2, 3, "R6");

    // R2 start clears a filled array; same-cycle strobe discarded
    runScan(0, 8, 0, 1, 0, "R5");
    @(negedge clk);
    startPulse = 1'b1; evictLeaf = 3'd1;
    inStrobe = 1'b1; inReal = 1'b1; inLeaf = 3'd1; inIndex = 3;
    @(negedge clk);
    startPulse = 1'b0; inStrobe = 1'b0;
    chk(scanDone == 1'b0, "R2 done cleared by start", scanDone, 1'b0);
    for (int i = 0; i < NSLOT; i++) begin expValid[i] = 1'b0; expPtr[i] = 0; end
    repeat (3) @(negedge clk);
    checkSlots("R2");

    summary();
  end

endmodule